// File: doc/BRIEF.md
# Dual-Mode Synchronous Serial Slave Port

This block is the slave side of a synchronous serial link. Through it a host reads and writes a bank of 32 byte-wide registers that sit outside the block. The serial clock, chip select and data pins are oversampled by the system clock `clk`. Every transfer opens with one instruction byte. After it come one to four data bytes, most significant bit first. Each byte of a write leaves the port on a valid/ready write stream. For each byte of a read the port sends an address out on `rd_addr`, takes the byte from `rd_data`, and shifts it back to the host.

The pin arrangement is picked at run time with `two_wire`. In 3-wire mode the host drives `sdi` and the port answers on `sdo`. In 2-wire mode a single bidirectional pin, modelled as `sdio_i`/`sdio_o`/`sdio_oe`, carries data in both directions. The port drives that pin only during the data phase of a read. A separate port reset, `io_rst_n`, returns the serial state machine to its idle state and touches nothing else. A write byte that is already waiting on the stream survives this reset.

Write stream rules: `wr_valid` rises with `wr_addr`/`wr_data`. All three hold steady until a cycle in which `wr_ready` is high. The serial host cannot be stalled. If a later write byte completes while the earlier one is still waiting, the later byte is dropped. The read side is plain: `rd_data` must follow `rd_addr` within one `clk` cycle.

Top module: `dual_serial_port`

## Requirements
- R1: Input bits are captured on rising edges of `sclk` while `cs_n` is low. The first 8 bits form the instruction, MSB first: bit 7 = 1 for read and 0 for write, bits 6:5 = byte count minus one, bits 4:0 = start register address.
- R2: A write transfer puts each completed data byte on `wr_data`, with `wr_addr` equal to the start address plus the byte's index (modulo 32).
- R3: While `cs_n` is high, both `sdo_oe` and `sdio_oe` are 0.
- R4: In 3-wire mode (`two_wire`=0) a read returns the byte at the start address, then the bytes at the following addresses, on `sdo_o`. The MSB of each byte comes first, and each bit changes after a falling edge of `sclk`. `sdo_oe` is 1 while `cs_n` is low and `sdio_oe` stays 0.
- R5: `wr_valid`, `wr_addr` and `wr_data` hold steady while `wr_valid` is high and `wr_ready` is low. A write byte that completes during such a stall is discarded.
- R6: In 2-wire mode (`two_wire`=1) input is taken from `sdio_i`. `sdio_oe` stays 0 through the whole instruction byte and throughout every write, and becomes 1 only after the instruction byte of a read has been received. Read data then appears on `sdio_o`, and `sdo_oe` stays 0.
- R7: A low level on `io_rst_n` returns the serial state machine to the instruction phase, even while `cs_n` stays low, and leaves a pending write byte on the stream unchanged.
- R8: Raising `cs_n` in the middle of a transfer aborts it. The next transfer starts again at its instruction byte.
- R9: Data bytes sent after the count given in the instruction are ignored and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset of the whole block |
| io_rst_n | input | 1 | Active-low reset of the serial state machine only |
| two_wire | input | 1 | 1 = bidirectional 2-wire data, 0 = separate in/out pins |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data input, 3-wire mode |
| sdo_o | output | 1 | Serial data output value, 3-wire mode |
| sdo_oe | output | 1 | Output enable of the serial data output pin |
| sdio_i | input | 1 | Bidirectional pin, input value |
| sdio_o | output | 1 | Bidirectional pin, output value |
| sdio_oe | output | 1 | Bidirectional pin, output enable |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Consumer accepts the write byte |
| wr_addr | output | 5 | Register address of the write byte |
| wr_data | output | 8 | Write byte |
| rd_addr | output | 5 | Register address requested for read data |
| rd_data | input | 8 | Register contents for `rd_addr` |

## Verification
A serial clock edge reaches the state machine after the two synchronizer stages plus one edge-detect register. The result is registered on the following `clk` edge. So a captured bit, a decoded instruction, a write byte or a new output bit is due about four `clk` cycles after the `sclk` edge that causes it. A read byte is fetched one cycle after its address is set. The bench holds each `sclk` level for eight `clk` cycles and samples output pins and enables on falling `clk` edges just before the next rising `sclk`. Every result therefore has at least four cycles of margin. Stream and reset checks are made only after the transfer has ended and the stream has had cycles to settle.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_INSTR,
    ST_WRITE,
    ST_READ,
    ST_DONE
  } sps_state_e;

  typedef struct packed {
    logic              rd;
    logic [CNT_W-1:0]  cnt_m1;
    logic [ADDR_W-1:0] addr;
  } sps_instr_t;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{rst_val[g]}};
      else        chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sps_fsm.sv
module sps_fsm
  import sps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo_bit,
  output logic              rd_phase
);
  sps_state_e        st;
  logic              sclk_q, rise, fall;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] sh, sh_next, out_sh;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left;
  logic              load_pend, is_rd;
  sps_instr_t        ins;

  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign sh_next = {sh[BYTE_W-2:0], din_s};
  assign ins     = sps_instr_t'(sh_next);
  assign rd_addr = addr_q;
  assign rd_phase = is_rd && (st != ST_INSTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_INSTR; sclk_q <= 1'b0; bit_cnt <= '0; sh <= '0; out_sh <= '0;
      addr_q <= '0; left <= '0; load_pend <= 1'b0; is_rd <= 1'b0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; sdo_bit <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      load_pend <= 1'b0;
      if (load_pend) out_sh <= rd_data;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (!io_rst_n || cs_s) begin
        st <= ST_INSTR; bit_cnt <= '0; is_rd <= 1'b0;
      end else if (rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        case (st)
          ST_INSTR: begin
            sh <= sh_next;
            if (&bit_cnt) begin
              addr_q <= ins.addr;
              left   <= ins.cnt_m1;
              is_rd  <= ins.rd;
              st     <= ins.rd ? ST_READ : ST_WRITE;
              load_pend <= ins.rd;
            end
          end
          ST_WRITE: begin
            sh <= sh_next;
            if (&bit_cnt) begin
              if (!wr_valid || wr_ready) begin
                wr_valid <= 1'b1;
                wr_addr  <= addr_q;
                wr_data  <= sh_next;
              end
              addr_q <= addr_q + 1'b1;
              left   <= left - 1'b1;
              if (left == '0) st <= ST_DONE;
            end
          end
          ST_READ: begin
            if (&bit_cnt) begin
              addr_q <= addr_q + 1'b1;
              left   <= left - 1'b1;
              if (left == '0) st <= ST_DONE;
              else load_pend <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fall && st == ST_READ) begin
        sdo_bit <= out_sh[~bit_cnt];
      end
    end
  end

  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  a_r8_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (st == ST_INSTR && bit_cnt == '0));
  a_r7_io_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rst_n |=> (st == ST_INSTR && !rd_phase));
  a_r9_no_extra_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && $past(st == ST_DONE)) |-> !$rose(wr_valid));
endmodule

// File: rtl/sps_pad.sv
module sps_pad (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic two_wire,
  input  logic rd_phase,
  input  logic sdo_bit,
  output logic sdo_o,
  output logic sdo_oe,
  output logic sdio_o,
  output logic sdio_oe
);
  assign sdo_o   = sdo_bit;
  assign sdio_o  = sdo_bit;
  assign sdo_oe  = ~cs_n & ~two_wire;
  assign sdio_oe = ~cs_n & two_wire & rd_phase;

  a_r3_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sdo_oe && !sdio_oe));
  a_r6_sdio_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (two_wire && rd_phase));
endmodule

// File: rtl/dual_serial_port.sv
module dual_serial_port
  import sps_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_rst_n,
  input  logic              two_wire,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  logic [2:0] raw, synced;
  logic       sdo_bit, rd_phase;

  assign raw = {cs_n, sclk, two_wire ? sdio_i : sdi};

  sps_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .rst_val(3'b100), .sync_o(synced)
  );

  sps_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .io_rst_n(io_rst_n),
    .cs_s(synced[2]), .sclk_s(synced[1]), .din_s(synced[0]),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo_bit(sdo_bit), .rd_phase(rd_phase)
  );

  sps_pad u_pad (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .two_wire(two_wire),
    .rd_phase(rd_phase), .sdo_bit(sdo_bit),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );
endmodule

// File: tb/dual_serial_port_bench.sv
module dual_serial_port_bench;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, io_rst_n = 1, two_wire = 0, cs_n = 1, sclk = 0;
  logic sdi = 0, sdio_i = 0, wr_ready = 1;
  logic sdo_o, sdo_oe, sdio_o, sdio_oe, wr_valid;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [32];
  int acc = 0, n_chk = 0, n_bad = 0;
  logic oe_or, sdo_oe_and;

  always #5 clk = ~clk;

  dual_serial_port u_dual_serial_port (
    .clk(clk), .rst_n(rst_n), .io_rst_n(io_rst_n), .two_wire(two_wire),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign rd_data = mem[rd_addr];

  always @(posedge clk) if (wr_valid && wr_ready) begin
    mem[wr_addr] <= wr_data;
    acc <= acc + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_slot(input logic b, output logic o);
    sdi = b; sdio_i = b;
    idle(HALF);
    o = two_wire ? sdio_o : sdo_o;
    oe_or = oe_or | sdio_oe;
    sdo_oe_and = sdo_oe_and & sdo_oe;
    sclk = 1; idle(HALF); sclk = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_slot(b[i], r[i]);
  endtask

  task automatic cs_lo();
    oe_or = 0; sdo_oe_and = 1; cs_n = 0; idle(4);
  endtask

  task automatic cs_hi();
    idle(4); cs_n = 1; idle(12);
  endtask

  task automatic xfer(input logic [7:0] ins, input int nb, input logic [31:0] tx,
                      output logic [31:0] rx, output logic ins_oe);
    logic [7:0] r;
    cs_lo();
    send_byte(ins, r);
    ins_oe = oe_or;
    rx = '0;
    for (int b = 0; b < nb; b++) begin
      send_byte(tx[31-8*b -: 8], r);
      rx[31-8*b -: 8] = r;
    end
    cs_hi();
  endtask

  task automatic t_reset();
    chk(!sdo_oe && !sdio_oe, "R3 reset hiz", {sdo_oe, sdio_oe}, 0);
    chk(!wr_valid, "R2 reset wr_valid", wr_valid, 0);
  endtask

  task automatic t_write3();
    logic [31:0] rx; logic io; int a0 = acc;
    two_wire = 0;
    xfer(8'b0_11_00011, 4, 32'h11_22_33_44, rx, io);
    chk(mem[3] == 8'h11 && mem[4] == 8'h22, "R1 R2 write bytes 3,4", {mem[3], mem[4]}, 16'h1122);
    chk(mem[5] == 8'h33 && mem[6] == 8'h44, "R2 write bytes 5,6", {mem[5], mem[6]}, 16'h3344);
    chk(acc - a0 == 4, "R2 write count", acc - a0, 4);
  endtask

  task automatic t_read3();
    logic [31:0] rx; logic io;
    logic [23:0] exp = {mem[4], mem[5], mem[6]};
    two_wire = 0;
    xfer(8'b1_10_00100, 3, 32'h0, rx, io);
    chk(rx[31:8] == exp, "R4 3-wire read data", rx[31:8], exp);
    chk(!oe_or && sdo_oe_and, "R4 oe during 3-wire read", {oe_or, sdo_oe_and}, 1);
    chk(!sdo_oe && !sdio_oe, "R3 hiz after cs_n high", {sdo_oe, sdio_oe}, 0);
  endtask

  task automatic t_two_wire();
    logic [31:0] rx; logic io;
    two_wire = 1;
    xfer(8'b0_01_10100, 2, 32'hC3_5A_00_00, rx, io);
    chk(mem[20] == 8'hC3 && mem[21] == 8'h5A, "R6 2-wire write", {mem[20], mem[21]}, 16'hC35A);
    chk(!oe_or, "R6 no drive during write", oe_or, 0);
    xfer(8'b1_01_10100, 2, 32'h0, rx, io);
    chk(rx[31:16] == 16'hC35A, "R6 2-wire read data", rx[31:16], 16'hC35A);
    chk(!io, "R6 no drive during instruction", io, 0);
    chk(oe_or && !sdo_oe_and, "R6 sdio driven, sdo not", {oe_or, sdo_oe_and}, 2);
    two_wire = 0;
  endtask

  task automatic t_excess();
    logic [31:0] rx; logic io; int a0 = acc; logic [7:0] m11 = mem[11];
    xfer(8'b0_00_01010, 3, 32'h9E_77_66_00, rx, io);
    chk(mem[10] == 8'h9E, "R9 counted byte written", mem[10], 8'h9E);
    chk(mem[11] == m11 && acc - a0 == 1, "R9 extra bytes ignored", acc - a0, 1);
  endtask

  task automatic t_abort();
    logic o; logic [31:0] rx; logic io; int a0 = acc;
    cs_lo();
    for (int i = 0; i < 4; i++) bit_slot(1'b0, o);
    cs_hi();
    xfer(8'b0_00_01100, 1, 32'hD2_00_00_00, rx, io);
    chk(mem[12] == 8'hD2 && acc - a0 == 1, "R8 restart after abort", mem[12], 8'hD2);
  endtask

  task automatic t_ioreset();
    logic [7:0] r; int a0 = acc;
    cs_lo();
    send_byte(8'b0_00_01110, r);
    for (int i = 0; i < 4; i++) bit_slot(1'b1, r[0]);
    io_rst_n = 0; idle(4); io_rst_n = 1; idle(4);
    send_byte(8'b0_00_01111, r);
    send_byte(8'h6B, r);
    cs_hi();
    chk(mem[15] == 8'h6B && acc - a0 == 1, "R7 io reset back to instruction", mem[15], 8'h6B);
  endtask

  task automatic t_stall();
    logic [31:0] rx; logic io; int a0 = acc; logic [7:0] m25 = mem[25];
    wr_ready = 0;
    xfer(8'b0_01_11000, 2, 32'hA5_3C_00_00, rx, io);
    chk(wr_valid && wr_addr == 5'd24 && wr_data == 8'hA5, "R5 held first byte",
        wr_data, 8'hA5);
    io_rst_n = 0; idle(4); io_rst_n = 1; idle(4);
    chk(wr_valid && wr_data == 8'hA5 && wr_addr == 5'd24, "R7 pending write kept",
        wr_data, 8'hA5);
    wr_ready = 1; idle(4);
    chk(mem[24] == 8'hA5 && !wr_valid, "R5 accepted after ready", mem[24], 8'hA5);
    chk(mem[25] == m25 && acc - a0 == 1, "R5 overrun byte dropped", acc - a0, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'(i * 7 + 3);
    idle(5); rst_n = 1; idle(5);
    t_reset();
    t_write3();
    t_read3();
    t_two_wire();
    t_excess();
    t_abort();
    t_ioreset();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule